// File: doc/BRIEF.md
# SPI Master Chip-Select Hold and Slave Desynchronization Watchdog

This block finishes each frame of an SPI master. While the data shifter reports a frame in progress, the block holds the active-low slave select asserted. When the shifter reports that the final bit has gone out, the block keeps the select asserted for a programmable number of internal clock cycles. That final bit is the parity bit when parity is in use. The number of cycles is the 5-bit hold setting plus one, so the hold lasts from 1 to 32 cycles.

The select then goes inactive and a watchdog starts. The watchdog counts SPI clock periods, using a tick that the clock generator supplies once per period, and it watches the slave's active-low enable line. If the line is still asserted when the programmed number of periods has passed, the slave has missed clock edges. The block then sets a sticky desynchronization flag, which stays set until the clear input is pulsed.

Both functions act only in master mode.

Top module: `spi_cs_hold_wdog`

## Requirements
- R1: When `master_i` is low, `cs_n_o` stays high whatever the other inputs do, and `desync_o` never goes from 0 to 1.
- R2: In master mode, `cs_n_o` is low in every cycle in which `busy_i` is high.
- R3: In master mode, after the clock edge that samples `done_i` high, `cs_n_o` stays low for exactly `hold_cfg_i`+1 cycles and then goes high. A setting of 2 gives 3 cycles, 0 gives 1 cycle and 31 gives 32 cycles.
- R4: A `done_i` pulse that arrives while the hold is running is ignored. The hold length is not extended.
- R5: The watchdog arms one cycle after `cs_n_o` goes high. If `ena_n_i` stays low (slave enable active), `desync_o` rises on the clock edge that samples the `to_cfg_i`-th `tick_i` pulse, and not earlier.
- R6: If the synchronized `ena_n_i` is high (slave enable inactive) before the timeout expires, the watchdog stops and `desync_o` stays 0, however many ticks follow.
- R7: A `to_cfg_i` value of 0 disables the watchdog, so `desync_o` stays 0.
- R8: `desync_o` stays 1 through later frames until `clr_i` is pulsed, and then reads 0.
- R9: `ena_n_i` passes through a two-flop synchronizer. A rise on `ena_n_i` is not seen by the watchdog at the second clock edge after the rise. It is seen from the third edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = master mode |
| busy_i | input | 1 | Frame in progress, from the shifter |
| done_i | input | 1 | One-cycle pulse at the end of the last bit (data or parity) |
| tick_i | input | 1 | One-cycle pulse once per SPI clock period |
| ena_n_i | input | 1 | Slave enable, active low, asynchronous |
| hold_cfg_i | input | 5 | Select hold setting; hold = value + 1 cycles |
| to_cfg_i | input | 8 | Watchdog timeout in SPI clock periods; 0 disables |
| clr_i | input | 1 | Clears the desynchronization flag |
| cs_n_o | output | 1 | Slave select, active low |
| desync_o | output | 1 | Sticky desynchronization flag |

## Verification
A corrupted hold counter shows up as a select release that comes one or more cycles early or late. The release edge is measured to the exact cycle for the minimum, maximum and middle hold settings, and for a repeated end pulse. A wrong watchdog count or state shows up as a flag that rises one tick early or late, or that rises after the slave has released. The flag is sampled just before and just after the deciding tick. Synchronizer depth errors are caught by a tick placed on the one edge where two stages and three stages of delay give different outcomes.

// File: rtl/spi_csh_pkg.sv
package spi_csh_pkg;
    typedef enum logic {
        WD_IDLE  = 1'b0,
        WD_ARMED = 1'b1
    } wd_state_e;
endpackage

// File: rtl/csh_sync.sv
module csh_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/csh_hold.sv
module csh_hold #(
    parameter int HOLD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              done_i,
    input  logic [HOLD_W-1:0] hold_cfg_i,
    output logic              hold_o,
    output logic              release_o
);
    typedef struct packed {
        logic              active;
        logic [HOLD_W-1:0] cnt;
        logic              rel;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d     = q;
        d.rel = 1'b0;
        if (!q.active) begin
            if (done_i && master_i) begin
                d.active = 1'b1;
                d.cnt    = hold_cfg_i;
            end
        end else if (q.cnt == '0) begin
            d.active = 1'b0;
            d.rel    = 1'b1;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold_o    = q.active;
    assign release_o = q.rel;

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.cnt != '0) |=> (q.active && q.cnt == HOLD_W'($past(q.cnt) - 1'b1))); // R4
    AST_RELEASE_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> !hold_o); // R3
    AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o); // R3
endmodule

// File: rtl/csh_wdog.sv
module csh_wdog
    import spi_csh_pkg::*;
#(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_i,
    input  logic            start_i,
    input  logic            ena_idle_i,
    input  logic            tick_i,
    input  logic [TO_W-1:0] to_cfg_i,
    input  logic            clr_i,
    output logic            desync_o
);
    typedef struct packed {
        wd_state_e       st;
        logic [TO_W-1:0] cnt;
        logic            flag;
    } wd_t;

    wd_t  d, q;
    logic hit;

    always_comb begin
        d   = q;
        hit = 1'b0;
        case (q.st)
            WD_IDLE: begin
                if (start_i && master_i && to_cfg_i != '0) begin
                    d.st  = WD_ARMED;
                    d.cnt = to_cfg_i;
                end
            end
            WD_ARMED: begin
                if (!master_i || ena_idle_i) begin
                    d.st = WD_IDLE;
                end else if (tick_i) begin
                    if (q.cnt == TO_W'(1)) begin
                        hit  = 1'b1;
                        d.st = WD_IDLE;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            default: d.st = WD_IDLE;
        endcase
        if (clr_i) d.flag = 1'b0;
        if (hit)   d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: WD_IDLE, cnt: '0, flag: 1'b0};
        else        q <= d;
    end

    assign desync_o = q.flag;

    AST_DESYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !clr_i) |=> q.flag); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && q.st == WD_IDLE) |=> !q.flag); // R8
    AST_ZERO_NEVER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == WD_IDLE && to_cfg_i == '0) |=> q.st == WD_IDLE); // R7
    AST_SLAVE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && !q.flag) |=> !q.flag); // R1
    AST_RELEASED_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == WD_ARMED && ena_idle_i) |=> q.st == WD_IDLE); // R6
endmodule

// File: rtl/spi_cs_hold_wdog.sv
module spi_cs_hold_wdog #(
    parameter int HOLD_W    = 5,
    parameter int TO_W      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              tick_i,
    input  logic              ena_n_i,
    input  logic [HOLD_W-1:0] hold_cfg_i,
    input  logic [TO_W-1:0]   to_cfg_i,
    input  logic              clr_i,
    output logic              cs_n_o,
    output logic              desync_o
);
    logic hold_w;
    logic release_w;
    logic ena_idle_w;

    csh_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ena_n_i),
        .sync_o  (ena_idle_w)
    );

    csh_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_i   (master_i),
        .done_i     (done_i),
        .hold_cfg_i (hold_cfg_i),
        .hold_o     (hold_w),
        .release_o  (release_w)
    );

    csh_wdog #(.TO_W(TO_W)) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_i   (master_i),
        .start_i    (release_w),
        .ena_idle_i (ena_idle_w),
        .tick_i     (tick_i),
        .to_cfg_i   (to_cfg_i),
        .clr_i      (clr_i),
        .desync_o   (desync_o)
    );

    assign cs_n_o = !(master_i && (busy_i || hold_w));

    AST_RELEASE_RAISES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_w && !busy_i) |-> cs_n_o); // R3
endmodule

// File: tb/spi_cs_hold_wdog_bench.sv
module spi_cs_hold_wdog_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_i = 1'b1;
    logic       busy_i = 1'b0;
    logic       done_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       ena_n_i = 1'b1;
    logic [4:0] hold_cfg_i = '0;
    logic [7:0] to_cfg_i = '0;
    logic       clr_i = 1'b0;
    logic       cs_n_o;
    logic       desync_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_cs_hold_wdog u_spi_cs_hold_wdog (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .busy_i(busy_i),
        .done_i(done_i), .tick_i(tick_i), .ena_n_i(ena_n_i),
        .hold_cfg_i(hold_cfg_i), .to_cfg_i(to_cfg_i), .clr_i(clr_i),
        .cs_n_o(cs_n_o), .desync_o(desync_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_once();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic run_frame(input int hold, input bit redo, output int len);
        int n;
        hold_cfg_i = 5'(hold);
        @(negedge clk);
        busy_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(cs_n_o == 1'b0, "R2", cs_n_o, 0);
        end
        busy_i = 1'b0;
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        n = 0;
        while (cs_n_o == 1'b0 && n < 100) begin
            n++;
            done_i = (redo && n == 2);
            @(negedge clk);
        end
        done_i = 1'b0;
        len = n;
    endtask

    task automatic t_hold(input int hold);
        int len;
        run_frame(hold, 1'b0, len);
        check(len == hold + 1, "R3", len, hold + 1);
        wait_cyc(3);
    endtask

    task automatic t_redo();
        int len;
        run_frame(5, 1'b1, len);
        check(len == 6, "R4", len, 6);
        wait_cyc(3);
    endtask

    task automatic t_timeout();
        int len;
        to_cfg_i = 8'd3;
        ena_n_i = 1'b0;
        run_frame(1, 1'b0, len);
        wait_cyc(2);
        tick_once();
        tick_once();
        check(desync_o == 1'b0, "R5 early", desync_o, 0);
        tick_once();
        check(desync_o == 1'b1, "R5", desync_o, 1);
        ena_n_i = 1'b1;
        run_frame(0, 1'b0, len);
        wait_cyc(4);
        check(desync_o == 1'b1, "R8 sticky", desync_o, 1);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check(desync_o == 1'b0, "R8 clear", desync_o, 0);
    endtask

    task automatic t_release();
        int len;
        to_cfg_i = 8'd2;
        ena_n_i = 1'b0;
        run_frame(0, 1'b0, len);
        wait_cyc(2);
        tick_once();
        ena_n_i = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < 5; i++) tick_once();
        check(desync_o == 1'b0, "R6", desync_o, 0);
    endtask

    task automatic t_sync();
        int len;
        to_cfg_i = 8'd1;
        ena_n_i = 1'b0;
        wait_cyc(3);
        run_frame(0, 1'b0, len);
        wait_cyc(2);
        ena_n_i = 1'b1;
        @(negedge clk);
        tick_once();
        check(desync_o == 1'b1, "R9 latency", desync_o, 1);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        ena_n_i = 1'b0;
        wait_cyc(3);
        run_frame(0, 1'b0, len);
        wait_cyc(2);
        ena_n_i = 1'b1;
        wait_cyc(2);
        tick_once();
        check(desync_o == 1'b0, "R9 seen", desync_o, 0);
    endtask

    task automatic t_zero();
        int len;
        to_cfg_i = 8'd0;
        ena_n_i = 1'b0;
        run_frame(2, 1'b0, len);
        wait_cyc(2);
        for (int i = 0; i < 10; i++) tick_once();
        check(desync_o == 1'b0, "R7", desync_o, 0);
        ena_n_i = 1'b1;
        wait_cyc(3);
    endtask

    task automatic t_slave();
        int highs;
        master_i = 1'b0;
        to_cfg_i = 8'd1;
        ena_n_i = 1'b0;
        hold_cfg_i = 5'd4;
        highs = 0;
        @(negedge clk);
        busy_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            highs += cs_n_o;
        end
        busy_i = 1'b0;
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            highs += cs_n_o;
            tick_once();
        end
        check(highs == 11, "R1 cs", highs, 11);
        check(desync_o == 1'b0, "R1 desync", desync_o, 0);
        master_i = 1'b1;
        ena_n_i = 1'b1;
    endtask

    initial begin
        wait_cyc(3);
        check(cs_n_o == 1'b1, "reset cs", cs_n_o, 1);
        check(desync_o == 1'b0, "reset desync", desync_o, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        t_hold(2);
        t_hold(0);
        t_hold(31);
        t_redo();
        t_timeout();
        t_release();
        t_sync();
        t_zero();
        t_slave();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule